// File: doc/BRIEF.md
# Dual Selectable-Rate Clock Synthesizer

This block makes two independent square-wave clocks from one fast reference clock, nominally 77.76 MHz. Each output picks one of eight telecom line rates. The choice uses two fields: a one-bit family select and a two-bit rate code. With the family bit at 0 the rates come from the 2.048 MHz series. With the family bit at 1 they come from the 1.544 MHz series. Each rate code step doubles the frequency.

Each output is the most significant bit of its own phase accumulator. On every reference edge the accumulator adds a fixed increment, and that increment is looked up from the selected rate. The increment values are worked out at elaboration, so the hardware holds no divider and does no runtime arithmetic. No filtering loop follows the accumulator, so every output edge falls on a reference edge. The output therefore carries peak-to-peak edge jitter of up to one reference period, about 12.9 ns, and that is accepted.

A change to any control field takes effect on the next reference edge. The accumulators are never cleared by a control change, so the phase stays continuous. The `settled` flag drops whenever a control field changes and rises again a fixed number of cycles later. All control and status pins are plain level signals. There is no data stream, so there is no handshake.

Top module: `dual_rate_synth`

## Requirements
- R1: While `rst` is sampled high at a clock edge, both accumulators are cleared. After that edge `synth_a`, `synth_b` and `settled` are all low.
- R2: With the family bit at 0, rate code n (0 to 3) gives an output whose average frequency is 2.048 MHz × 2^n for a 77.76 MHz reference, that is f_clk × 2.048·2^n / 77.76. Over a counting window the rising-edge count is within one edge plus 1 ppm of that value.
- R3: With the family bit at 1, rate code n gives an average frequency of 1.544 MHz × 2^n, that is f_clk × 1.544·2^n / 77.76, within the same tolerance as R2.
- R4: Each output follows only its own code and family fields, so the two outputs can run at different rates at the same time.
- R5: No high or low phase of an output is shorter than the ideal half period minus one reference cycle, and every phase lasts at least two reference cycles.
- R6: A control change is used from the next clock edge on. It does not clear the accumulator, so an output that is high stays high through the edge right after a switch from 1.544 MHz to 2.048 MHz taken just after its rising edge.
- R7: After a control change is sampled at an edge, or after reset is released, `settled` is low. It rises after exactly SETTLE_CYCLES clock edges, counting from the edge that sampled the change or from the first edge with reset low.
- R8: While no control field changes, `settled` stays high once it has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_code_a | input | 2 | Rate code for output A |
| sel_fam_a | input | 1 | Family select for output A (0: 2.048 MHz series, 1: 1.544 MHz series) |
| sel_code_b | input | 2 | Rate code for output B |
| sel_fam_b | input | 1 | Family select for output B |
| synth_a | output | 1 | Synthesized clock A |
| synth_b | output | 1 | Synthesized clock B |
| settled | output | 1 | High once the controls have been steady for SETTLE_CYCLES edges |

## Verification
The bench walks through all eight rate selections on both outputs at the same time. Output B always runs the mirror selection of output A, so a swapped family series, a wrong code shift or cross-wired outputs each show up as an edge count far outside the one-edge tolerance. At each selection the bench also records the shortest high or low phase. A wrong increment, or a reset that fires mid-cycle, would produce a phase shorter than the ideal half period allows. A design that clears the accumulator on a control change drops the output low right after a switch made just after a rising edge, and the bench checks for exactly that. The bench also times `settled` edge by edge after reset and after a change, which exposes a counter that is off by one or one that never re-arms.

// File: rtl/synth_pkg.sv
package synth_pkg;

  typedef struct packed {
    logic       fam;
    logic [1:0] code;
  } rate_sel_t;

  // Increment for table index {fam, code}: round(f_out / f_ref * 2^acc_w)
  function automatic longint unsigned rate_inc(input int unsigned idx,
                                               input int unsigned acc_w,
                                               input longint unsigned ref_hz);
    longint unsigned f;
    f = ((idx & 4) != 0) ? 64'd1544000 : 64'd2048000;
    f = f << (idx & 3);
    return ((f << acc_w) + ref_hz / 2) / ref_hz;
  endfunction

endpackage

// File: rtl/synth_rate_lut.sv
module synth_rate_lut
  import synth_pkg::*;
#(
  parameter int unsigned     ACC_W  = 32,
  parameter longint unsigned REF_HZ = 64'd77760000
) (
  input  rate_sel_t          sel,
  output logic [ACC_W-1:0]   inc
);
  localparam int N_ENT = 8;

  logic [ACC_W-1:0] tbl [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [ACC_W-1:0] ENT = ACC_W'(rate_inc(e, ACC_W, REF_HZ));
    assign tbl[e] = ENT;
  end

  assign inc = tbl[{sel.fam, sel.code}];
endmodule

// File: rtl/synth_phase_acc.sv
module synth_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc,
  output logic             wave
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + inc;
  end

  assign wave = acc[ACC_W-1];
endmodule

// File: rtl/synth_settle.sv
module synth_settle #(
  parameter int unsigned CTL_W         = 6,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctl,
  output logic             settled
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYCLES);

  logic [CTL_W-1:0] prev;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    prev <= ctl;
    if (rst)               cnt <= CNT_INIT;
    else if (ctl != prev)  cnt <= CNT_INIT;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign settled = (cnt == '0);
endmodule

// File: rtl/dual_rate_synth.sv
module dual_rate_synth
  import synth_pkg::*;
#(
  parameter int unsigned     ACC_W         = 32,
  parameter longint unsigned REF_HZ        = 64'd77760000,
  parameter int unsigned     SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_code_a,
  input  logic       sel_fam_a,
  input  logic [1:0] sel_code_b,
  input  logic       sel_fam_b,
  output logic       synth_a,
  output logic       synth_b,
  output logic       settled
);
  localparam int NUM_OUT = 2;
  localparam int SEL_W   = $bits(rate_sel_t);
  localparam int CTL_W   = NUM_OUT * SEL_W;

  rate_sel_t          sel  [NUM_OUT];
  logic [NUM_OUT-1:0] wave;
  logic [CTL_W-1:0]   ctl_all;

  assign sel[0] = '{fam: sel_fam_a, code: sel_code_a};
  assign sel[1] = '{fam: sel_fam_b, code: sel_code_b};

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_ch
    logic [ACC_W-1:0] inc;

    synth_rate_lut #(.ACC_W(ACC_W), .REF_HZ(REF_HZ)) u_lut (
      .sel (sel[ch]),
      .inc (inc)
    );

    synth_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk  (clk),
      .rst  (rst),
      .inc  (inc),
      .wave (wave[ch])
    );

    assign ctl_all[ch*SEL_W +: SEL_W] = sel[ch];
  end

  synth_settle #(.CTL_W(CTL_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl_all),
    .settled (settled)
  );

  assign synth_a = wave[0];
  assign synth_b = wave[1];
endmodule

// File: rtl/synth_checker.sv
module synth_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sel_code_a,
  input logic       sel_fam_a,
  input logic [1:0] sel_code_b,
  input logic       sel_fam_b,
  input logic       synth_a,
  input logic       synth_b,
  input logic       settled
);
  logic [5:0] ctl;
  assign ctl = {sel_fam_b, sel_code_b, sel_fam_a, sel_code_a};

  // R1: reset leaves outputs and flag low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!synth_a && !synth_b && !settled));

  // R5: every high and low phase lasts at least two reference cycles
  a_r5_min_high_a: assert property (@(posedge clk) disable iff (rst)
    $rose(synth_a) |=> synth_a);
  a_r5_min_low_a: assert property (@(posedge clk) disable iff (rst)
    $fell(synth_a) |=> !synth_a);
  a_r5_min_high_b: assert property (@(posedge clk) disable iff (rst)
    $rose(synth_b) |=> synth_b);
  a_r5_min_low_b: assert property (@(posedge clk) disable iff (rst)
    $fell(synth_b) |=> !synth_b);

  // R7: a sampled control change drops the flag
  a_r7_change_unsettles: assert property (@(posedge clk) disable iff (rst)
    (ctl != $past(ctl)) |=> !settled);

  // R8: steady controls keep the flag high
  a_r8_settled_holds: assert property (@(posedge clk) disable iff (rst)
    (settled && ctl == $past(ctl)) |=> settled);
endmodule

bind dual_rate_synth synth_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_code_a (sel_code_a),
  .sel_fam_a  (sel_fam_a),
  .sel_code_b (sel_code_b),
  .sel_fam_b  (sel_fam_b),
  .synth_a    (synth_a),
  .synth_b    (synth_b),
  .settled    (settled)
);

// File: tb/sim_dual_rate_synth.sv
`timescale 1ns/1ps
module sim_dual_rate_synth;
  localparam int  SETTLE = 4;
  localparam int  WIN    = 12000;
  localparam real FREF   = 77.76e6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_code_a = 2'd0;
  logic       sel_fam_a  = 1'b0;
  logic [1:0] sel_code_b = 2'd0;
  logic       sel_fam_b  = 1'b0;
  logic       synth_a, synth_b, settled;

  int tests  = 0;
  int failed = 0;

  always #4 clk = ~clk;

  dual_rate_synth #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst(rst),
    .sel_code_a(sel_code_a), .sel_fam_a(sel_fam_a),
    .sel_code_b(sel_code_b), .sel_fam_b(sel_fam_b),
    .synth_a(synth_a), .synth_b(synth_b), .settled(settled)
  );

  task automatic chk(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  function automatic real target_hz(input int idx);
    real base;
    base = ((idx & 4) != 0) ? 1.544e6 : 2.048e6;
    return base * real'(1 << (idx & 3));
  endfunction

  // Count rising edges and the shortest full phase on both outputs
  task automatic run_window(input int ia, input int ib);
    int   rises [2];
    int   minrun [2];
    int   runlen [2];
    bit   seen [2];
    logic pv [2];
    logic cur [2];
    int   idx [2];
    real  f, expe, half;
    idx[0] = ia; idx[1] = ib;
    @(negedge clk);
    {sel_fam_a, sel_code_a} = 3'(ia);
    {sel_fam_b, sel_code_b} = 3'(ib);
    pv[0] = synth_a; pv[1] = synth_b;
    for (int k = 0; k < 2; k++) begin
      rises[k] = 0; minrun[k] = 1 << 30; runlen[k] = 0; seen[k] = 1'b0;
    end
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      cur[0] = synth_a; cur[1] = synth_b;
      for (int k = 0; k < 2; k++) begin
        if (cur[k] != pv[k]) begin
          if (cur[k]) rises[k]++;
          if (seen[k] && runlen[k] < minrun[k]) minrun[k] = runlen[k];
          seen[k] = 1'b1;
          runlen[k] = 1;
        end else begin
          runlen[k]++;
        end
        pv[k] = cur[k];
      end
    end
    for (int k = 0; k < 2; k++) begin
      f    = target_hz(idx[k]);
      expe = real'(WIN) * f / FREF;
      half = FREF / (2.0 * f);
      chk((real'(rises[k]) - expe <= 1.0 + expe * 1e-6) &&
          (expe - real'(rises[k]) <= 1.0 + expe * 1e-6),
          $sformatf("%s%s output %0d sel %0d: rising edges actual %0d expected %f",
                    ((idx[k] & 4) != 0) ? "R3" : "R2", (k == 1) ? "/R4" : "",
                    k, idx[k], rises[k], expe));
      chk(real'(minrun[k]) >= half - 1.0 && minrun[k] >= 2,
          $sformatf("R5 output %0d sel %0d: shortest phase actual %0d expected >= %f",
                    k, idx[k], minrun[k], half - 1.0));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    int n;
    bit held;
    // R1: reset state
    repeat (5) @(negedge clk);
    chk(synth_a == 1'b0, $sformatf("R1 synth_a actual %0b expected 0", synth_a));
    chk(synth_b == 1'b0, $sformatf("R1 synth_b actual %0b expected 0", synth_b));
    chk(settled == 1'b0, $sformatf("R1 settled actual %0b expected 0", settled));

    // R7: release of reset
    rst = 1'b0;
    n = 0;
    while (!settled && n < 50) begin @(negedge clk); n++; end
    chk(n == SETTLE, $sformatf("R7 edges to settle after reset actual %0d expected %0d", n, SETTLE));

    // R8: steady controls keep settled high
    held = 1'b1;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (!settled) held = 1'b0; end
    chk(held, $sformatf("R8 settled during steady controls actual %0b expected 1", held));

    // R7: control change
    sel_code_b = 2'd2;
    @(negedge clk);
    chk(settled == 1'b0, $sformatf("R7 settled after change actual %0b expected 0", settled));
    n = 0;
    while (!settled && n < 50) begin @(negedge clk); n++; end
    chk(n == SETTLE, $sformatf("R7 edges to settle after change actual %0d expected %0d", n, SETTLE));

    // R2 R3 R4 R5: full sweep, output B mirrored
    for (int i = 0; i < 8; i++) run_window(i, 7 - i);

    // R6: switch right after a rising edge; phase must carry on
    {sel_fam_a, sel_code_a} = 3'd4;
    repeat (2) @(negedge clk);
    n = 0;
    while (synth_a && n < 200) begin @(negedge clk); n++; end
    while (!synth_a && n < 200) begin @(negedge clk); n++; end
    {sel_fam_a, sel_code_a} = 3'd0;
    @(negedge clk);
    chk(synth_a == 1'b1, $sformatf("R6 synth_a after switch actual %0b expected 1", synth_a));

    finish_run();
  end
endmodule